// File: doc/BRIEF.md
# Alternate Bus Master Ownership Handshake

This block sits inside a device that can take over a shared bus from its default owner. A local user asserts a "need bus" level. The block turns that level into an active-low request on the bus and then watches the active-low grant input. A grant alone is not enough to take the bus. The block also waits until the cycle of the present owner has ended, which it sees as the address strobe and the bus-busy indicator both inactive in the same sampled clock. It then drives its active-low acknowledge and, on the same clock edge, drops its request.

While the acknowledge is held, the user runs its own transfers. It pulses a "done" input when it has finished, and the block then releases the acknowledge. A programmable cool-down keeps the request line quiet for a short time after each release. If the user drops its need before it has become owner, the block withdraws the request and never acknowledges. The three bus inputs pass through a synchronizer of parameterized depth (`SYNC_STAGES`, default 2) before the control logic uses them.

Top module: `bus_claim_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, `req_n_o` and `ack_n_o` are 1 and `owned_o` is 0.
- R2: When idle with `need_i` high, `req_n_o` goes to 0 on the next clock edge.
- R3: While requesting, if a synchronized sample shows `grant_n_i`=0, `strobe_n_i`=1 and `busy_n_i`=1, then on the next edge `ack_n_o` becomes 0 and `req_n_o` becomes 1 together.
- R4: While either `strobe_n_i` or `busy_n_i` is 0 in the synchronized sample, `ack_n_o` stays 1 even with the grant present, and `req_n_o` stays 0.
- R5: Once asserted, `ack_n_o` stays 0 until `done_i` is seen high, whatever `grant_n_i` does.
- R6: With `ack_n_o`=0 and `done_i`=1 at a clock edge, `ack_n_o` is 1 after that edge.
- R7: After the edge that releases the acknowledge, `req_n_o` stays 1 for `HOLDOFF_CYCLES`+1 edges. With `need_i` still high, it falls to 0 on the next edge after those.
- R8: If `need_i` is low while requesting and not yet owner, `req_n_o` returns to 1 on the next edge and `ack_n_o` is never asserted.
- R9: `owned_o` is 1 exactly when `ack_n_o` is 0.
- R10: `req_n_o` and `ack_n_o` are never 0 at the same time.
- R11: A grant that arrives while no request is pending has no effect: `ack_n_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| need_i | input | 1 | User wants the bus (level) |
| done_i | input | 1 | User has finished its transfers |
| grant_n_i | input | 1 | Bus grant, active low |
| strobe_n_i | input | 1 | Address strobe of the present owner, active low |
| busy_n_i | input | 1 | Bus-busy indicator, active low |
| req_n_o | output | 1 | Bus request, active low |
| ack_n_o | output | 1 | Ownership acknowledge, active low |
| owned_o | output | 1 | High while this device owns the bus |

## Verification
The case that is hardest to reach from the ports is a grant that is present while the previous owner still holds the bus, and in particular a bus that is released one indicator at a time. The stimulus holds the grant low and first keeps the strobe active. It then frees the strobe but keeps the busy line active, and only then frees both. Every step is given enough clocks to pass the synchronizer, so each partial release reaches the control logic before the next one. A further directed case drops the need in this deferred state, so that the withdrawal path is tested after a grant has already been seen.

// File: rtl/bus_claim_pkg.sv
package bus_claim_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ASK   = 3'd1,
      ST_DEFER = 3'd2,
      ST_OWN   = 3'd3,
      ST_COOL  = 3'd4
   } claim_state_t;
endpackage

// File: rtl/bus_claim_sync.sv
module bus_claim_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("bus_claim_sync: STAGES must be at least 1");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("bus_claim_sync: WIDTH must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         logic [WIDTH-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= '1;
            else        stage_q <= d;
         end
         assign q = stage_q;
      end else begin : g_chain
         logic [WIDTH-1:0] pipe_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) pipe_q[i] <= '1;
            end else begin
               pipe_q[0] <= d;
               for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
            end
         end
         assign q = pipe_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/bus_claim_holdoff.sv
module bus_claim_holdoff #(
   parameter int HOLDOFF_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expired
);
   localparam int CW = (HOLDOFF_CYCLES < 1) ? 1 : $clog2(HOLDOFF_CYCLES + 1);

   generate
      if (HOLDOFF_CYCLES < 1) begin : g_bad_holdoff
         $error("bus_claim_holdoff: HOLDOFF_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    remain_q <= '0;
      else if (start)                remain_q <= CW'(HOLDOFF_CYCLES);
      else if (remain_q != CW'(0))   remain_q <= remain_q - CW'(1);
   end

   assign expired = (remain_q == CW'(0));
endmodule

// File: rtl/bus_claim_fsm.sv
module bus_claim_fsm
   import bus_claim_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         need,
   input  logic         done,
   input  logic         granted,
   input  logic         bus_free,
   input  logic         cool_over,
   output logic         cool_start,
   output claim_state_t state
);
   claim_state_t state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         ST_IDLE:  if (need && cool_over) state_d = ST_ASK;
         ST_ASK: begin
            if (!need)                     state_d = ST_IDLE;
            else if (granted && bus_free)  state_d = ST_OWN;
            else if (granted)              state_d = ST_DEFER;
         end
         ST_DEFER: begin
            if (!need)         state_d = ST_IDLE;
            else if (bus_free) state_d = ST_OWN;
         end
         ST_OWN:   if (done)      state_d = ST_COOL;
         ST_COOL:  if (cool_over) state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_d;
   end

   assign cool_start = (state == ST_OWN) && done;
endmodule

// File: rtl/bus_claim_ctrl.sv
module bus_claim_ctrl
   import bus_claim_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int HOLDOFF_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic need_i,
   input  logic done_i,
   input  logic grant_n_i,
   input  logic strobe_n_i,
   input  logic busy_n_i,
   output logic req_n_o,
   output logic ack_n_o,
   output logic owned_o
);
   localparam int BUS_BITS = 3;

   logic [BUS_BITS-1:0] bus_raw, bus_s;
   logic granted, bus_free, cool_start, cool_over;
   claim_state_t state;

   assign bus_raw = {grant_n_i, strobe_n_i, busy_n_i};

   bus_claim_sync #(.STAGES(SYNC_STAGES), .WIDTH(BUS_BITS)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
   );

   assign granted  = !bus_s[2];
   assign bus_free = bus_s[1] && bus_s[0];

   bus_claim_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_holdoff (
      .clk(clk), .rst_n(rst_n), .start(cool_start), .expired(cool_over)
   );

   bus_claim_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .need(need_i), .done(done_i),
      .granted(granted), .bus_free(bus_free), .cool_over(cool_over),
      .cool_start(cool_start), .state(state)
   );

   assign req_n_o = !((state == ST_ASK) || (state == ST_DEFER));
   assign ack_n_o = !(state == ST_OWN);
   assign owned_o = (state == ST_OWN);
endmodule

// File: rtl/bus_claim_checker.sv
module bus_claim_checker #(
   parameter int HOLDOFF_CYCLES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic need_i,
   input logic done_i,
   input logic req_n_o,
   input logic ack_n_o,
   input logic owned_o
);
   localparam int GAP_MAX = HOLDOFF_CYCLES + 2;
   localparam int GW      = $clog2(GAP_MAX + 1);

   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      gap_q <= GW'(GAP_MAX);
      else if (!ack_n_o)               gap_q <= '0;
      else if (gap_q != GW'(GAP_MAX))  gap_q <= gap_q + GW'(1);
   end

   assert_req_after_need_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n_o) |-> $past(need_i));

   assert_swap_req_for_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_n_o) |-> ($past(!req_n_o) && req_n_o));

   assert_ack_held_until_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_n_o) |-> $past(done_i));

   assert_release_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n_o && done_i) |=> ack_n_o);

   assert_cooldown_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n_o) |-> (gap_q >= GW'(GAP_MAX)));

   assert_withdraw_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_n_o && !need_i) |=> (req_n_o && ack_n_o));

   assert_owned_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
      owned_o == !ack_n_o);

   assert_never_both_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!req_n_o && !ack_n_o));
endmodule

bind bus_claim_ctrl bus_claim_checker #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_checker (
   .clk(clk), .rst_n(rst_n), .need_i(need_i), .done_i(done_i),
   .req_n_o(req_n_o), .ack_n_o(ack_n_o), .owned_o(owned_o)
);

// File: tb/bus_claim_ctrl_test.sv
`timescale 1ns/1ps
module bus_claim_ctrl_test;
   localparam int SYNC = 2;
   localparam int HOLD = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic need = 1'b0, done = 1'b0;
   logic grant_n = 1'b1, strobe_n = 1'b1, busy_n = 1'b1;
   logic req_n, ack_n, owned;
   int checks = 0, failures = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   bus_claim_ctrl #(.SYNC_STAGES(SYNC), .HOLDOFF_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .need_i(need), .done_i(done),
      .grant_n_i(grant_n), .strobe_n_i(strobe_n), .busy_n_i(busy_n),
      .req_n_o(req_n), .ack_n_o(ack_n), .owned_o(owned)
   );

   task automatic chk(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one edge; outputs then sampled at the falling edge, with R9/R10 checked each time
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      chk("R9 owned mirrors ack", owned, !ack_n);
      chk("R10 req and ack not both low", (!req_n && !ack_n), 1'b0);
   endtask

   task automatic flush();
      need = 1'b0; done = 1'b0; grant_n = 1'b1; strobe_n = 1'b1; busy_n = 1'b1;
      repeat (SYNC + HOLD + 4) step();
   endtask

   task automatic t_reset();
      chk("R1 req_n in reset", req_n, 1'b1);
      chk("R1 ack_n in reset", ack_n, 1'b1);
      chk("R1 owned in reset", owned, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      step();
      chk("R1 req_n after reset", req_n, 1'b1);
      chk("R1 ack_n after reset", ack_n, 1'b1);
   endtask

   task automatic t_idle_grant();
      grant_n = 1'b0;
      for (int i = 0; i < SYNC + 3; i++) begin
         step();
         chk("R11 grant without request ack_n", ack_n, 1'b1);
         chk("R11 grant without request req_n", req_n, 1'b1);
      end
      flush();
   endtask

   task automatic t_basic();
      need = 1'b1;
      step();
      chk("R2 request after need", req_n, 1'b0);
      grant_n = 1'b0;
      for (int i = 0; i < SYNC; i++) begin
         step();
         chk("R3 no ack before sync delay", ack_n, 1'b1);
      end
      step();
      chk("R3 ack asserted", ack_n, 1'b0);
      chk("R3 request dropped with ack", req_n, 1'b1);
      chk("R9 owned high", owned, 1'b1);
      grant_n = 1'b1;
      for (int i = 0; i < SYNC + 3; i++) begin
         step();
         chk("R5 ack held after grant removed", ack_n, 1'b0);
      end
      done = 1'b1;
      step();
      done = 1'b0;
      chk("R6 ack released on done", ack_n, 1'b1);
      chk("R9 owned low after release", owned, 1'b0);
      for (int i = 0; i < HOLD + 1; i++) begin
         step();
         chk("R7 request held off", req_n, 1'b1);
      end
      step();
      chk("R7 request after cooldown", req_n, 1'b0);
      need = 1'b0;
      step();
      chk("R8 request withdrawn", req_n, 1'b1);
      flush();
   endtask

   task automatic t_busy_wait();
      need = 1'b1;
      step();
      chk("R2 request raised", req_n, 1'b0);
      grant_n = 1'b0; strobe_n = 1'b0; busy_n = 1'b1;
      for (int i = 0; i < SYNC + 2; i++) begin
         step();
         chk("R4 strobe active blocks ack", ack_n, 1'b1);
         chk("R4 request kept under strobe", req_n, 1'b0);
      end
      strobe_n = 1'b1; busy_n = 1'b0;
      for (int i = 0; i < SYNC + 2; i++) begin
         step();
         chk("R4 busy active blocks ack", ack_n, 1'b1);
         chk("R4 request kept under busy", req_n, 1'b0);
      end
      busy_n = 1'b1;
      for (int i = 0; i < SYNC; i++) begin
         step();
         chk("R4 free not yet synchronized", ack_n, 1'b1);
      end
      step();
      chk("R3 ack once bus free", ack_n, 1'b0);
      chk("R3 request dropped", req_n, 1'b1);
      need = 1'b0; done = 1'b1;
      step();
      done = 1'b0;
      chk("R6 release", ack_n, 1'b1);
      flush();
   endtask

   task automatic t_withdraw();
      need = 1'b1;
      step();
      chk("R2 request raised", req_n, 1'b0);
      need = 1'b0;
      step();
      chk("R8 withdraw before grant req_n", req_n, 1'b1);
      grant_n = 1'b0;
      for (int i = 0; i < SYNC + 2; i++) begin
         step();
         chk("R8 no ack after withdraw", ack_n, 1'b1);
      end
      flush();
      // withdraw after a grant has been seen but the bus is still busy
      need = 1'b1;
      step();
      grant_n = 1'b0; busy_n = 1'b0;
      repeat (SYNC + 2) step();
      chk("R4 deferred, no ack", ack_n, 1'b0 ^ 1'b1);
      need = 1'b0;
      step();
      chk("R8 withdraw while deferred req_n", req_n, 1'b1);
      busy_n = 1'b1;
      for (int i = 0; i < SYNC + 2; i++) begin
         step();
         chk("R8 withdraw while deferred ack_n", ack_n, 1'b1);
      end
      flush();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_idle_grant();
      t_basic();
      t_busy_wait();
      t_withdraw();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule